// File: doc/BRIEF.md
# Dual-Master Round-Robin Memory Interconnect

This block connects two requesters, a processor port and a DMA port, to three targets: the flash interface (which also serves the system-memory area), on-chip SRAM and the peripheral bridge. Each requester places one single-beat transfer on its port: address, read or write, size code and write data. The block decodes the address, converts it to the target's physical address and forwards the transfer to that target. When both requesters reach the same target, a round-robin arbiter for that target picks one and stalls the other. Requesters reaching different targets proceed in parallel.

The lowest part of the map is an alias window. A 2-bit remap input decides whether that window shows main flash, system memory or SRAM. The chosen memory can still be reached at its own base address. An address that falls outside every mapped region finishes at once with an error and reaches no target.

A requester holds its request and fields steady until it sees `*_ready`. A target asserts its ready in the cycle it completes the selected transfer. Ready may follow select in the same cycle or after any number of wait cycles.

Top module: `dual_master_matrix`

## Requirements
- R1: Addresses in [0x0800_0000, 0x0800_0000+FLASH_BYTES) select the flash port, and the flash port receives the address unchanged.
- R2: Addresses in [0x1FFF_0000, 0x1FFF_0000+SYSMEM_BYTES) (system memory) also select the flash port, with the address unchanged.
- R3: Addresses in [0x2000_0000, 0x2000_0000+SRAM_BYTES) select the SRAM port, with the address unchanged.
- R4: Addresses in [0x4000_0000, PERIPH_LAST] select the bridge port, with the address unchanged.
- R5: An address below ALIAS_BYTES is an alias. The target sees base+address, where base is chosen by `remap`: 2'b00 or 2'b10 gives flash (0x0800_0000), 2'b01 gives system memory (0x1FFF_0000), 2'b11 gives SRAM (0x2000_0000). The result is then decoded as in R1 to R3.
- R6: A reserved address gets `*_ready`=1 and `*_err`=1 in the same cycle it is requested. No slave select is raised for it. This includes an alias whose converted address lies beyond the chosen memory.
- R7: A lone requester to an idle target is granted in the same cycle. Its `*_ready` follows the target's ready combinationally, and `*_ready` is never high without `*_req`.
- R8: Each target has a favour pointer that is set to the CPU at reset. On every contested grant, the winner is the favoured requester, and the pointer then moves to the loser.
- R9: A grant is held until the target returns ready. While it is held, the other requester is stalled (`*_ready`=0) even if it arrives later. Transfers to different targets complete in the same cycle.
- R10: The granted requester's write flag, size code and write data reach the selected target. That target's read data is returned on the requester's `*_rdata`, and `*_err` is 0 for mapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| remap | input | 2 | Alias window target select |
| cpu_req | input | 1 | Processor transfer request |
| cpu_addr | input | 32 | Processor byte address |
| cpu_write | input | 1 | Processor write (1) or read (0) |
| cpu_size | input | 2 | Processor size code |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Processor read data |
| cpu_ready | output | 1 | Processor transfer complete |
| cpu_err | output | 1 | Processor transfer hit a reserved address |
| dma_req | input | 1 | DMA transfer request |
| dma_addr | input | 32 | DMA byte address |
| dma_write | input | 1 | DMA write (1) or read (0) |
| dma_size | input | 2 | DMA size code |
| dma_wdata | input | DW | DMA write data |
| dma_rdata | output | DW | DMA read data |
| dma_ready | output | 1 | DMA transfer complete |
| dma_err | output | 1 | DMA transfer hit a reserved address |
| fl_sel | output | 1 | Flash target select |
| fl_addr | output | 32 | Flash target physical address |
| fl_write | output | 1 | Flash target write flag |
| fl_size | output | 2 | Flash target size code |
| fl_wdata | output | DW | Flash target write data |
| fl_rdata | input | DW | Flash target read data |
| fl_ready | input | 1 | Flash target completion |
| sr_sel | output | 1 | SRAM target select |
| sr_addr | output | 32 | SRAM target physical address |
| sr_write | output | 1 | SRAM target write flag |
| sr_size | output | 2 | SRAM target size code |
| sr_wdata | output | DW | SRAM target write data |
| sr_rdata | input | DW | SRAM target read data |
| sr_ready | input | 1 | SRAM target completion |
| br_sel | output | 1 | Bridge target select |
| br_addr | output | 32 | Bridge target physical address |
| br_write | output | 1 | Bridge target write flag |
| br_size | output | 2 | Bridge target size code |
| br_wdata | output | DW | Bridge target write data |
| br_rdata | input | DW | Bridge target read data |
| br_ready | input | 1 | Bridge target completion |

## Verification
The bench builds the block with SRAM_BYTES reduced to 0x1000 and all other parameters at their defaults. The small SRAM means an alias offset of 0x2000 with SRAM remapped lands past the end of SRAM, so the remap-into-hole error case can be reached with a short address. The default 512 KB flash size and peripheral end of 0x4002_63FF let the bench probe the first address past flash and past the bridge region. The target models in the bench use a wait count that can be set per test, which makes held grants, late arrivals and the alternation of the favour pointer visible over several cycles.

// File: rtl/dual_master_matrix.sv
module dual_master_matrix #(
  parameter int          DW           = 32,
  parameter logic [31:0] FLASH_BYTES  = 32'h0008_0000,
  parameter logic [31:0] SYSMEM_BYTES = 32'h0000_7000,
  parameter logic [31:0] SRAM_BYTES   = 32'h0002_4000,
  parameter logic [31:0] ALIAS_BYTES  = 32'h0008_0000,
  parameter logic [31:0] PERIPH_LAST  = 32'h4002_63FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    remap,
  input  logic          cpu_req,
  input  logic [31:0]   cpu_addr,
  input  logic          cpu_write,
  input  logic [1:0]    cpu_size,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_ready,
  output logic          cpu_err,
  input  logic          dma_req,
  input  logic [31:0]   dma_addr,
  input  logic          dma_write,
  input  logic [1:0]    dma_size,
  input  logic [DW-1:0] dma_wdata,
  output logic [DW-1:0] dma_rdata,
  output logic          dma_ready,
  output logic          dma_err,
  output logic          fl_sel,
  output logic [31:0]   fl_addr,
  output logic          fl_write,
  output logic [1:0]    fl_size,
  output logic [DW-1:0] fl_wdata,
  input  logic [DW-1:0] fl_rdata,
  input  logic          fl_ready,
  output logic          sr_sel,
  output logic [31:0]   sr_addr,
  output logic          sr_write,
  output logic [1:0]    sr_size,
  output logic [DW-1:0] sr_wdata,
  input  logic [DW-1:0] sr_rdata,
  input  logic          sr_ready,
  output logic          br_sel,
  output logic [31:0]   br_addr,
  output logic          br_write,
  output logic [1:0]    br_size,
  output logic [DW-1:0] br_wdata,
  input  logic [DW-1:0] br_rdata,
  input  logic          br_ready
);
  localparam logic [31:0] FLASH_BASE  = 32'h0800_0000;
  localparam logic [31:0] SYS_BASE    = 32'h1FFF_0000;
  localparam logic [31:0] SRAM_BASE   = 32'h2000_0000;
  localparam logic [31:0] PERIPH_BASE = 32'h4000_0000;
  localparam logic [1:0]  T_FL = 2'd0, T_SR = 2'd1, T_BR = 2'd2, T_NONE = 2'd3;
  localparam int          NS = 3;

  logic          m_req [2];
  logic [31:0]   m_addr[2];
  logic          m_wr  [2];
  logic [1:0]    m_sz  [2];
  logic [DW-1:0] m_wd  [2];
  logic [31:0]   phys  [2];
  logic [1:0]    tgt   [2];
  logic          m_rdy [2];
  logic          m_err [2];
  logic [DW-1:0] m_rd  [2];

  assign m_req = '{cpu_req, dma_req};
  assign m_addr = '{cpu_addr, dma_addr};
  assign m_wr = '{cpu_write, dma_write};
  assign m_sz = '{cpu_size, dma_size};
  assign m_wd = '{cpu_wdata, dma_wdata};

  logic          s_rdy[NS];
  logic [DW-1:0] s_rd [NS];
  assign s_rdy = '{fl_ready, sr_ready, br_ready};
  assign s_rd  = '{fl_rdata, sr_rdata, br_rdata};

  function automatic logic in_win(input logic [31:0] a, input logic [31:0] base,
                                  input logic [31:0] len);
    return (a >= base) && ((a - base) < len);
  endfunction

  always_comb begin
    for (int m = 0; m < 2; m++) begin
      if (m_addr[m] < ALIAS_BYTES) begin
        case (remap)
          2'b01:   phys[m] = SYS_BASE + m_addr[m];
          2'b11:   phys[m] = SRAM_BASE + m_addr[m];
          default: phys[m] = FLASH_BASE + m_addr[m];
        endcase
      end else begin
        phys[m] = m_addr[m];
      end
      if (in_win(phys[m], FLASH_BASE, FLASH_BYTES) || in_win(phys[m], SYS_BASE, SYSMEM_BYTES))
        tgt[m] = T_FL;
      else if (in_win(phys[m], SRAM_BASE, SRAM_BYTES))
        tgt[m] = T_SR;
      else if (phys[m] >= PERIPH_BASE && phys[m] <= PERIPH_LAST)
        tgt[m] = T_BR;
      else
        tgt[m] = T_NONE;
    end
  end

  logic busy[NS], own[NS], pri[NS], gnt[NS], act[NS], hit0[NS], hit1[NS];

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      hit0[s] = m_req[0] && (tgt[0] == 2'(s));
      hit1[s] = m_req[1] && (tgt[1] == 2'(s));
      if (busy[s])           gnt[s] = own[s];
      else if (hit0[s] && hit1[s]) gnt[s] = pri[s];
      else                   gnt[s] = hit1[s];
      act[s] = busy[s] || hit0[s] || hit1[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    for (int s = 0; s < NS; s++) begin
      if (!rst_n) begin
        busy[s] <= 1'b0;
        own[s]  <= 1'b0;
        pri[s]  <= 1'b0;
      end else begin
        busy[s] <= act[s] && !s_rdy[s];
        own[s]  <= gnt[s];
        if (!busy[s] && hit0[s] && hit1[s]) pri[s] <= !gnt[s];
      end
    end
  end

  assign fl_sel = act[0];  assign fl_addr = phys[gnt[0]];  assign fl_write = m_wr[gnt[0]];
  assign fl_size = m_sz[gnt[0]];  assign fl_wdata = m_wd[gnt[0]];
  assign sr_sel = act[1];  assign sr_addr = phys[gnt[1]];  assign sr_write = m_wr[gnt[1]];
  assign sr_size = m_sz[gnt[1]];  assign sr_wdata = m_wd[gnt[1]];
  assign br_sel = act[2];  assign br_addr = phys[gnt[2]];  assign br_write = m_wr[gnt[2]];
  assign br_size = m_sz[gnt[2]];  assign br_wdata = m_wd[gnt[2]];

  always_comb begin
    for (int m = 0; m < 2; m++) begin
      m_err[m] = 1'b0;
      case (tgt[m])
        T_FL: begin m_rdy[m] = act[0] && (gnt[0] == 1'(m)) && s_rdy[0]; m_rd[m] = s_rd[0]; end
        T_SR: begin m_rdy[m] = act[1] && (gnt[1] == 1'(m)) && s_rdy[1]; m_rd[m] = s_rd[1]; end
        T_BR: begin m_rdy[m] = act[2] && (gnt[2] == 1'(m)) && s_rdy[2]; m_rd[m] = s_rd[2]; end
        default: begin m_rdy[m] = 1'b1; m_err[m] = 1'b1; m_rd[m] = '0; end
      endcase
      m_rdy[m] = m_rdy[m] && m_req[m];
      m_err[m] = m_err[m] && m_req[m];
    end
  end

  assign cpu_ready = m_rdy[0];  assign cpu_err = m_err[0];  assign cpu_rdata = m_rd[0];
  assign dma_ready = m_rdy[1];  assign dma_err = m_err[1];  assign dma_rdata = m_rd[1];

  p_ready_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready |-> cpu_req) and (dma_ready |-> dma_req));

  p_err_selects_nothing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_err && !dma_req) |-> (cpu_ready && !fl_sel && !sr_sel && !br_sel));

  p_one_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && dma_req && tgt[0] == tgt[1] && tgt[0] != T_NONE) |-> !(cpu_ready && dma_ready));

  for (genvar s = 0; s < NS; s++) begin : g_chk
    p_grant_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (act[s] && !s_rdy[s]) |=> (act[s] && gnt[s] == $past(gnt[s])));
  end
endmodule

// File: tb/dual_master_matrix_tb.sv
module dual_master_matrix_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam logic [31:0] TAG[3] = '{32'hF1A5_0000, 32'h5A5A_0000, 32'h0B0B_0000};

  logic clk = 0, rst_n = 0;
  logic [1:0] remap = 0;
  logic cpu_req = 0, cpu_write = 0, dma_req = 0, dma_write = 0;
  logic [31:0] cpu_addr = 0, dma_addr = 0;
  logic [1:0] cpu_size = 0, dma_size = 0;
  logic [DW-1:0] cpu_wdata = 0, dma_wdata = 0;
  logic [DW-1:0] cpu_rdata, dma_rdata;
  logic cpu_ready, cpu_err, dma_ready, dma_err;
  logic fl_sel, sr_sel, br_sel, fl_write, sr_write, br_write;
  logic [31:0] fl_addr, sr_addr, br_addr;
  logic [1:0] fl_size, sr_size, br_size;
  logic [DW-1:0] fl_wdata, sr_wdata, br_wdata;
  logic fl_ready, sr_ready, br_ready;
  int wt[3] = '{0, 0, 0};
  int cn[3] = '{0, 0, 0};
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign fl_ready = fl_sel && (cn[0] == wt[0]);
  assign sr_ready = sr_sel && (cn[1] == wt[1]);
  assign br_ready = br_sel && (cn[2] == wt[2]);

  always_ff @(posedge clk) begin
    cn[0] <= (fl_sel && !fl_ready) ? cn[0] + 1 : 0;
    cn[1] <= (sr_sel && !sr_ready) ? cn[1] + 1 : 0;
    cn[2] <= (br_sel && !br_ready) ? cn[2] + 1 : 0;
  end

  dual_master_matrix #(.DW(DW), .SRAM_BYTES(32'h0000_1000)) u_dut (
    .clk, .rst_n, .remap,
    .cpu_req, .cpu_addr, .cpu_write, .cpu_size, .cpu_wdata, .cpu_rdata, .cpu_ready, .cpu_err,
    .dma_req, .dma_addr, .dma_write, .dma_size, .dma_wdata, .dma_rdata, .dma_ready, .dma_err,
    .fl_sel, .fl_addr, .fl_write, .fl_size, .fl_wdata, .fl_rdata(fl_addr ^ TAG[0]), .fl_ready,
    .sr_sel, .sr_addr, .sr_write, .sr_size, .sr_wdata, .sr_rdata(sr_addr ^ TAG[1]), .sr_ready,
    .br_sel, .br_addr, .br_write, .br_size, .br_wdata, .br_rdata(br_addr ^ TAG[2]), .br_ready);

  task automatic check(input string r, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  function automatic logic [31:0] saddr(input int p);
    return p == 0 ? fl_addr : p == 1 ? sr_addr : br_addr;
  endfunction

  function automatic logic [2:0] sels();
    return {br_sel, sr_sel, fl_sel};
  endfunction

  task automatic idle();
    @(negedge clk);
    cpu_req = 0; dma_req = 0;
  endtask

  task automatic lone_cpu(input string r, input logic [31:0] a, input int p, input logic [31:0] ph);
    @(negedge clk);
    cpu_req = 1; cpu_addr = a; cpu_write = 0;
    #1;
    check({r, " sel"}, 32'(sels()), 32'(3'b001 << p));
    check({r, " addr"}, saddr(p), ph);
    check({r, " ready"}, {31'b0, cpu_ready}, 1);
    check({r, " err"}, {31'b0, cpu_err}, 0);
    check({r, " rdata"}, cpu_rdata, ph ^ TAG[p]);
    idle();
  endtask

  task automatic reserved_cpu(input string r, input logic [31:0] a);
    @(negedge clk);
    cpu_req = 1; cpu_addr = a;
    #1;
    check({r, " ready+err"}, {30'b0, cpu_ready, cpu_err}, 3);
    check({r, " no sel"}, 32'(sels()), 0);
    idle();
  endtask

  task automatic t_reset();
    #1;
    check("R7 reset sel", 32'(sels()), 0);
    check("R7 reset ready", {30'b0, cpu_ready, dma_ready}, 0);
  endtask

  task automatic t_decode();
    lone_cpu("R1 flash", 32'h0800_0010, 0, 32'h0800_0010);
    lone_cpu("R1 flash top", 32'h0807_FFFC, 0, 32'h0807_FFFC);
    lone_cpu("R2 sysmem", 32'h1FFF_0040, 0, 32'h1FFF_0040);
    lone_cpu("R3 sram", 32'h2000_0080, 1, 32'h2000_0080);
    lone_cpu("R4 bridge", 32'h4001_3800, 2, 32'h4001_3800);
    lone_cpu("R4 bridge last", 32'h4002_63FC, 2, 32'h4002_63FC);
  endtask

  task automatic t_alias();
    remap = 2'b00; lone_cpu("R5 alias flash", 32'h0000_0100, 0, 32'h0800_0100);
    remap = 2'b01; lone_cpu("R5 alias sysmem", 32'h0000_0100, 0, 32'h1FFF_0100);
    remap = 2'b11; lone_cpu("R5 alias sram", 32'h0000_0100, 1, 32'h2000_0100);
    lone_cpu("R5 sram own base", 32'h2000_0100, 1, 32'h2000_0100);
    remap = 2'b10; lone_cpu("R5 alias code10", 32'h0000_0100, 0, 32'h0800_0100);
    remap = 2'b00;
  endtask

  task automatic t_reserved();
    reserved_cpu("R6 gap", 32'h3000_0000);
    reserved_cpu("R6 past bridge", 32'h4002_6400);
    reserved_cpu("R6 past flash", 32'h0808_0000);
    reserved_cpu("R6 past sram", 32'h2000_1000);
    remap = 2'b11;
    reserved_cpu("R6 alias hole", 32'h0000_2000);
    remap = 2'b00;
  endtask

  task automatic t_write_path();
    @(negedge clk);
    dma_req = 1; dma_addr = 32'h4000_4400; dma_write = 1; dma_size = 2'd1; dma_wdata = 32'hCAFE_1234;
    #1;
    check("R10 write flag", {31'b0, br_write}, 1);
    check("R10 size", {30'b0, br_size}, 1);
    check("R10 wdata", br_wdata, 32'hCAFE_1234);
    check("R10 dma ready", {30'b0, dma_ready, dma_err}, 2);
    idle();
    dma_write = 0; dma_size = 0;
  endtask

  task automatic t_contest();
    @(negedge clk);
    wt[0] = 2;
    cpu_req = 1; cpu_addr = 32'h0800_0A00;
    dma_req = 1; dma_addr = 32'h0800_0B00;
    #1;
    check("R8 cpu favoured first", fl_addr, 32'h0800_0A00);
    check("R9 both stalled c0", {30'b0, cpu_ready, dma_ready}, 0);
    @(negedge clk); #1;
    check("R9 grant kept c1", fl_addr, 32'h0800_0A00);
    check("R9 both stalled c1", {30'b0, cpu_ready, dma_ready}, 0);
    @(negedge clk); #1;
    check("R9 cpu done dma stalled", {30'b0, cpu_ready, dma_ready}, 2);
    check("R10 cpu rdata", cpu_rdata, 32'h0800_0A00 ^ TAG[0]);
    @(negedge clk);
    cpu_req = 0;
    #1;
    check("R9 dma takes over", fl_addr, 32'h0800_0B00);
    @(negedge clk); @(negedge clk); #1;
    check("R9 dma done", {31'b0, dma_ready}, 1);
    idle();
    cpu_req = 1; dma_req = 1;
    #1;
    check("R8 dma favoured second", fl_addr, 32'h0800_0B00);
    @(negedge clk); @(negedge clk); #1;
    check("R8 dma wins second", {30'b0, cpu_ready, dma_ready}, 1);
    @(negedge clk);
    dma_req = 0;
    #1;
    check("R8 cpu after dma", fl_addr, 32'h0800_0A00);
    @(negedge clk); @(negedge clk); #1;
    check("R8 cpu done", {31'b0, cpu_ready}, 1);
    idle();
    wt[0] = 0;
  endtask

  task automatic t_late_arrival();
    @(negedge clk);
    wt[1] = 3;
    dma_req = 1; dma_addr = 32'h2000_0040;
    #1;
    check("R7 lone dma granted", sr_addr, 32'h2000_0040);
    @(negedge clk);
    cpu_req = 1; cpu_addr = 32'h2000_0080;
    #1;
    check("R9 late cpu stalled", {30'b0, cpu_ready, dma_ready}, 0);
    check("R9 owner kept", sr_addr, 32'h2000_0040);
    @(negedge clk); @(negedge clk); #1;
    check("R9 dma completes first", {30'b0, cpu_ready, dma_ready}, 1);
    @(negedge clk);
    dma_req = 0;
    #1;
    check("R9 cpu follows", sr_addr, 32'h2000_0080);
    idle();
    wt[1] = 0;
  endtask

  task automatic t_parallel();
    @(negedge clk);
    cpu_req = 1; cpu_addr = 32'h0800_0200;
    dma_req = 1; dma_addr = 32'h4000_0400;
    #1;
    check("R9 parallel ready", {30'b0, cpu_ready, dma_ready}, 3);
    check("R9 parallel flash", fl_addr, 32'h0800_0200);
    check("R9 parallel bridge", br_addr, 32'h4000_0400);
    check("R10 dma rdata", dma_rdata, 32'h4000_0400 ^ TAG[2]);
    idle();
  endtask

  logic finished = 0;
  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_decode();
    t_alias();
    t_reserved();
    t_write_path();
    t_contest();
    t_late_arrival();
    t_parallel();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule